// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block derives the sampling enables for one asynchronous serial channel from the peripheral clock. It raises two single-cycle enables: a base tick at the oversampling rate, and a bit tick once per serial bit. A transmitter or receiver in the same clock domain consumes both enables. No derived clock is generated.

The rate comes from three settings. The first is an 8-bit divisor N. The second is a 2-bit prescale select n, which divides the clock by 4^n. The third is a pair of mode flags. One flag bypasses the divide-by-two stage (double speed). The other flag picks 8 instead of 16 base ticks per bit. In normal mode with 16x oversampling the bit rate is Pclk / (64 · 2^(2n-1) · (N+1)). Each mode flag halves the constant 64. A plain register port lets the CPU write and read the settings at any time. Every write restarts the whole divider chain, so a new rate starts from a clean phase. The block has no streaming data path, so every pin is a plain control or status pin and none takes back-pressure.

Top module: `rate_gen_top`

## Requirements
- R1: After reset the divisor register reads 0xFF and the mode register reads 0x00 (n=0, normal speed, 16x). With these defaults base ticks repeat every 512 cycles.
- R2: Register map. Address 0 holds the 8-bit divisor N. Address 1 holds the mode: bits [1:0] are n, bit 2 selects double speed, and bit 3 = 1 selects 8x (0 selects 16x). Bits [7:4] of the mode register read as 0 and ignore writes. A write to one address leaves the other register unchanged.
- R3: In normal mode base ticks repeat every D = 2·4^n·(N+1) clock cycles.
- R4: In double-speed mode base ticks repeat every D = 4^n·(N+1) clock cycles.
- R5: With bit 3 = 0, bit_tick rises on every 16th base tick and only in a cycle where base_tick is high.
- R6: With bit 3 = 1, bit_tick rises on every 8th base tick.
- R7: Any register write restarts the prescaler, the divisor counter, the halving stage and the base-tick count. The first base tick then appears in cycle D-1, and the first bit tick in cycle R·D-1. Cycle 0 is the cycle right after the write edge, and R is 16 or 8.
- R8: In normal mode base_tick is never high in two consecutive cycles.
- R9: The extreme divisors behave as specified. With N=0 in double speed and n=0, base_tick is high in every cycle. N=255 with n=3 gives a base period of 32768 cycles in normal mode and 16384 cycles in double-speed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select (0 divisor, 1 mode) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr, combinational |
| base_tick | output | 1 | Oversampling enable, one cycle wide |
| bit_tick | output | 1 | Once-per-bit enable, one cycle wide |

## Verification
The hardest setting to reach is the deepest divisor chain. With n=3, N=255, normal speed and 16x, one bit lasts over half a million cycles. So the bench measures base periods at the full depth and measures bit periods with small divisors. The oversampling count does not depend on the divisor, so small divisors still cover it. All sixteen mode combinations are then swept with N=0 and N=2. Because every write restarts the chain, each measurement is taken from a known phase. A further test rewrites the divisor partway through a period to show that the count starts over.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int PSEL_W = 2;
  localparam int MODE_W = PSEL_W + 2;

  typedef struct packed {
    logic              ratio_lo;
    logic              dbl;
    logic [PSEL_W-1:0] psel;
  } rate_mode_t;
endpackage

// File: rtl/rate_regs.sv
module rate_regs
  import rate_gen_pkg::*;
#(
  parameter int          DIV_W   = 8,
  parameter logic [7:0]  RST_DIV = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             addr,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] rdata,
  output logic [DIV_W-1:0] div_n,
  output rate_mode_t       mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n <= DIV_W'(RST_DIV);
      mode  <= '0;
    end else if (we) begin
      if (addr == 1'b0) div_n <= wdata;
      else              mode  <= rate_mode_t'(wdata[MODE_W-1:0]);
    end
  end

  always_comb begin
    if (addr == 1'b0) rdata = div_n;
    else              rdata = DIV_W'(mode);
  end
endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
  parameter int PSEL_W = 2,
  localparam int STEPS  = 1 << PSEL_W,
  localparam int PCNT_W = 2 * (STEPS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              pre_tick,
  output logic [PCNT_W-1:0] pcnt
);
  logic [STEPS-1:0] hit;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    localparam logic [PCNT_W-1:0] MASK = PCNT_W'((64'd1 << (2 * i)) - 64'd1);
    assign hit[i] = ((pcnt & MASK) == MASK);
  end

  assign pre_tick = hit[psel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (restart)  pcnt <= '0;
    else if (pre_tick) pcnt <= '0;
    else               pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] div_n,
  input  logic             dbl,
  output logic             base_tick,
  output logic [DIV_W-1:0] dcnt
);
  logic half;
  logic wrap;

  assign wrap      = pre_tick && (dcnt == div_n);
  assign base_tick = wrap && (dbl || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      half <= 1'b0;
    end else if (restart) begin
      dcnt <= '0;
      half <= 1'b0;
    end else if (wrap) begin
      dcnt <= '0;
      half <= ~half;
    end else if (pre_tick) begin
      dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rate_ovs.sv
module rate_ovs #(
  parameter int HI = 16,
  parameter int LO = 8,
  localparam int W = $clog2(HI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic base_tick,
  input  logic ratio_lo,
  output logic bit_tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  assign last     = ratio_lo ? W'(LO - 1) : W'(HI - 1);
  assign bit_tick = base_tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (restart)   cnt <= '0;
    else if (bit_tick)  cnt <= '0;
    else if (base_tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rate_gen_top.sv
module rate_gen_top
  import rate_gen_pkg::*;
#(
  parameter int         DIV_W   = 8,
  parameter logic [7:0] RST_DIV = 8'hFF,
  parameter int         OVS_HI  = 16,
  parameter int         OVS_LO  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic [DIV_W-1:0] cfg_rdata,
  output logic             base_tick,
  output logic             bit_tick
);
  localparam int PCNT_W = 2 * ((1 << PSEL_W) - 1);

  logic [DIV_W-1:0]  div_n;
  rate_mode_t        mode_q;
  logic              pre_tick;
  logic [PCNT_W-1:0] pcnt;
  logic [DIV_W-1:0]  dcnt;

  rate_regs #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .div_n(div_n), .mode(mode_q)
  );

  rate_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .psel(mode_q.psel),
    .pre_tick(pre_tick), .pcnt(pcnt)
  );

  rate_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .pre_tick(pre_tick),
    .div_n(div_n), .dbl(mode_q.dbl), .base_tick(base_tick), .dcnt(dcnt)
  );

  rate_ovs #(.HI(OVS_HI), .LO(OVS_LO)) u_ovs (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .base_tick(base_tick),
    .ratio_lo(mode_q.ratio_lo), .bit_tick(bit_tick)
  );
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk #(
  parameter int DIV_W  = 8,
  parameter int PCNT_W = 6,
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [3:0]        mode,
  input logic [PCNT_W-1:0] pcnt,
  input logic [DIV_W-1:0]  dcnt,
  input logic              base_tick,
  input logic              bit_tick
);
  logic [7:0] nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         nb <= '0;
    else if (cfg_we)    nb <= '0;
    else if (bit_tick)  nb <= '0;
    else if (base_tick) nb <= nb + 1'b1;
  end

  // R7
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (pcnt == '0 && dcnt == '0));

  // R5
  bit_with_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick);

  // R6
  bit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (nb == (mode[3] ? 8'(OVS_LO - 1) : 8'(OVS_HI - 1))));

  // R8
  base_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[2] && base_tick) |-> !$past(base_tick));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(mode));
endmodule

bind rate_gen_top rate_gen_chk #(
  .DIV_W(DIV_W), .PCNT_W(PCNT_W), .OVS_HI(OVS_HI), .OVS_LO(OVS_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode(mode_q),
  .pcnt(pcnt), .dcnt(dcnt), .base_tick(base_tick), .bit_tick(bit_tick)
);

// File: tb/sim_rate_gen_top.sv
module sim_rate_gen_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       base_tick;
  logic       bit_tick;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rate_gen_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_tick(base_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input bit a, input int exp, input string req);
    cfg_addr = a;
    #1;
    check(req, int'(cfg_rdata), exp);
  endtask

  // Cycle 0 is the current negedge, just after the write edge.
  task automatic measure(input int d, input int rr, input bit do_bit,
                         input string rb, input string rbit);
    int fb = -1, sb = -1, fbit = -1, k = 0;
    while (1) begin
      if (base_tick) begin
        if (fb < 0) fb = k; else if (sb < 0) sb = k;
      end
      if (bit_tick && fbit < 0) fbit = k;
      if (sb >= 0 && (!do_bit || fbit >= 0)) break;
      if (k > 2 * rr * d + 16) break;
      @(negedge clk); k++;
    end
    check(rb, fb, d - 1);
    check(rb, sb - fb, d);
    if (do_bit) check(rbit, fbit, rr * d - 1);
  endtask

  task automatic run_rate(input int n, input bit ds, input bit r8,
                          input int nv, input bit do_bit);
    int d  = (1 << (2 * n)) * (nv + 1) * (ds ? 1 : 2);
    int rr = r8 ? 8 : 16;
    wr(1'b0, 8'(nv));
    wr(1'b1, {4'b0, r8, ds, 2'(n)});
    measure(d, rr, do_bit, ds ? "R4" : "R3", r8 ? "R6" : "R5");
  endtask

  task automatic t_reset();
    int fb = -1, k = 0;
    rd_check(1'b0, 8'hFF, "R1");
    rd_check(1'b1, 0, "R1");
    while (k < 2000) begin
      if (base_tick) begin
        if (fb >= 0) break;
        fb = k;
      end
      @(negedge clk); k++;
    end
    check("R1", k - fb, 512);
  endtask

  task automatic t_map();
    wr(1'b1, 8'hFF);
    rd_check(1'b1, 8'h0F, "R2");
    wr(1'b0, 8'h05);
    rd_check(1'b0, 8'h05, "R2");
    rd_check(1'b1, 8'h0F, "R2");
    wr(1'b1, 8'h0F);
    measure(64 * 6, 8, 1'b1, "R2", "R2");
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 4; n++)
      for (int ds = 0; ds < 2; ds++)
        for (int r8 = 0; r8 < 2; r8++) begin
          run_rate(n, ds[0], r8[0], 0, 1'b1);
          run_rate(n, ds[0], r8[0], 2, 1'b1);
        end
  endtask

  task automatic t_extremes();
    int k = 0;
    bit all_hi = 1'b1;
    wr(1'b0, 8'd0);
    wr(1'b1, 8'b0000_0100);
    while (k < 20) begin
      if (!base_tick) all_hi = 1'b0;
      @(negedge clk); k++;
    end
    check("R9", int'(all_hi), 1);
    run_rate(0, 1'b0, 1'b0, 255, 1'b1);
    run_rate(3, 1'b1, 1'b0, 255, 1'b0);
    run_rate(3, 1'b0, 1'b0, 255, 1'b0);
  endtask

  task automatic t_restart();
    wr(1'b0, 8'd9);
    wr(1'b1, 8'b0000_0001);
    repeat (50) @(negedge clk);
    wr(1'b0, 8'd9);
    measure(80, 16, 1'b1, "R7", "R7");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_restart();
    t_sweep();
    t_extremes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule